// File: doc/BRIEF.md
# Dual-View Complex Data Memory

This block is a data memory that two masters share. A host reaches it over a 32-bit, byte-addressed bus. An accelerator reaches it over a 64-bit, word-addressed port. One accelerator word holds one complex sample. The real part sits in the low 32 bits and the imaginary part in the high 32 bits, and each part is a 32-bit single-precision float. The block treats both parts as opaque bits.

The storage is two single-port banks. The `cfg_stripe` pin selects how they are organised:

- **Striped (`cfg_stripe` = 1):** consecutive words alternate between the two banks, and the full 4096-word space is usable.
- **Mirrored (`cfg_stripe` = 0):** every write lands in both banks and reads come from bank 0. The usable space is one bank deep, and word addresses wrap at that depth.

Both request sides use valid/ready rules:

- **Accelerator side:** a request is taken in any cycle where `a_valid` is high. It has no ready pin and is never held off.
- **Host side:** a request is taken only in a cycle where both `h_valid` and `h_ready` are high. `h_ready` falls combinationally whenever `a_valid` is high. A host master must hold its request, unchanged, until it sees `h_ready` high at a clock edge.

Read data returns on both sides one cycle after acceptance, marked by a one-cycle `a_rvalid` or `h_rvalid` pulse. There is no back-pressure on the return path.

Top module: `cplx_dual_mem`

## Requirements
- R1: An accelerator request is accepted in every cycle where `a_valid` is high. For a read, `a_rvalid` is high in the next cycle and `a_rdata` carries the 64-bit word at `a_addr`. A read that immediately follows a write to the same word, with the mode unchanged, returns the written data.
- R2: A host address maps to word (`h_addr` - `HOST_BASE`) >> 3. All eight byte addresses 8k to 8k+7 above the base reach accelerator word k.
- R3: Host address bit 2 picks the half of the word. A value of 0 selects bits 31:0 (the real part) and a value of 1 selects bits 63:32 (the imaginary part). A host write changes only the selected half.
- R4: For an accepted host read, `h_rvalid` is high in the next cycle and `h_rdata` holds the selected 32-bit half.
- R5: In striped mode (`cfg_stripe` = 1), word address bit 0 selects the bank. All 4096 word addresses are distinct locations, and neighbouring words do not disturb each other.
- R6: In mirrored mode (`cfg_stripe` = 0), a write to word w updates index w mod 2048 in both banks, and a read returns bank 0. As a result, word w and word w+2048 alias. After a switch to striped mode, the mirrored content of index i appears at both word 2i and word 2i+1.
- R7: When `a_valid` and `h_valid` are both high, the accelerator is served and `h_ready` is low. The held host request is served on the first following cycle where `a_valid` is low. A cycle with `a_valid` high never produces `h_rvalid` in the next cycle, and the two read-valid outputs are never high together.
- R8: While `rst_n` is low, and in the first cycle after reset is released with no request, `a_rvalid` and `h_rvalid` are low. `h_ready` is high whenever `a_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stripe | input | 1 | Bank mode select: 1 means striped, 0 means mirrored |
| a_valid | input | 1 | Accelerator request valid |
| a_write | input | 1 | Accelerator request is a write |
| a_addr | input | 12 | Accelerator word address |
| a_wdata | input | 64 | Accelerator write word, with the imaginary part in the high half |
| a_rvalid | output | 1 | Accelerator read data valid |
| a_rdata | output | 64 | Accelerator read word |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted this cycle if `h_valid` is high |
| h_write | input | 1 | Host request is a write |
| h_addr | input | 32 | Host byte address (32-bit aligned) |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |

## Verification
The bench writes full words from the accelerator and reads them back through both halves of the host view. This separates a swapped real/imaginary mapping from a wrong shift in address translation. Host writes to a single half are followed by full-word accelerator reads, which expose any write that touches both halves. Writes to neighbouring words and to words 2048 apart in striped mode catch a wrong bank-select bit. The same patterns in mirrored mode, followed by reads after switching to striped mode, show whether both banks were really written. Finally, overlapping host and accelerator requests check the stall and the host access that follows it, both for a host write and for a host read that must see the accelerator's newer data.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  localparam int HALF_W = 32;
  localparam int WORD_W = 2 * HALF_W;
  localparam int LANES  = WORD_W / HALF_W;
  localparam int BANKS  = 2;

  typedef enum logic {
    MODE_MIRROR = 1'b0,
    MODE_STRIPE = 1'b1
  } bank_mode_e;

  // lane mask for a host access picking one half of the word
  function automatic logic [LANES-1:0] half_mask(input logic imag);
    return imag ? LANES'(2'b10) : LANES'(2'b01);
  endfunction
endpackage

// File: rtl/cdm_host_xlate.sv
module cdm_host_xlate
  import cdm_pkg::*;
#(
  parameter int          HAW       = 32,
  parameter int          WAW       = 12,
  parameter logic [31:0] HOST_BASE = 32'h4000_0000
) (
  input  logic [HAW-1:0]    haddr,
  input  logic [HALF_W-1:0] hwdata,
  output logic [WAW-1:0]    word_addr,
  output logic              imag_sel,
  output logic [LANES-1:0]  lane_mask,
  output logic [WORD_W-1:0] wide_wdata
);
  logic [HAW-1:0] offset;
  logic           unused_bits;

  assign offset      = haddr - HAW'(HOST_BASE);
  assign word_addr   = offset[WAW+2:3];
  assign imag_sel    = offset[2];
  assign lane_mask   = half_mask(offset[2]);
  assign wide_wdata  = {LANES{hwdata}};
  assign unused_bits = ^{offset[HAW-1:WAW+3], offset[1:0]};
endmodule

// File: rtl/cdm_bank_route.sv
module cdm_bank_route
  import cdm_pkg::*;
#(
  parameter int WAW = 12,
  localparam int IAW = WAW - 1
) (
  input  logic            stripe,
  input  logic [WAW-1:0]  word_addr,
  output logic [IAW-1:0]  idx,
  output logic [BANKS-1:0] bank_hit,
  output logic            rd_bank
);
  always_comb begin
    if (bank_mode_e'(stripe) == MODE_STRIPE) begin
      idx      = word_addr[WAW-1:1];
      bank_hit = word_addr[0] ? BANKS'(2'b10) : BANKS'(2'b01);
      rd_bank  = word_addr[0];
    end else begin
      idx      = word_addr[IAW-1:0];
      bank_hit = '1;
      rd_bank  = 1'b0;
    end
  end
endmodule

// File: rtl/cdm_bank.sv
module cdm_bank
  import cdm_pkg::*;
#(
  parameter int IAW = 11,
  localparam int DEPTH = 1 << IAW
) (
  input  logic              clk,
  input  logic              en,
  input  logic              wr,
  input  logic [LANES-1:0]  lane,
  input  logic [IAW-1:0]    idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (en && wr && lane[l])
        mem[idx][l*HALF_W +: HALF_W] <= wdata[l*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (en && !wr) rdata <= mem[idx];
  end
endmodule

// File: rtl/cplx_dual_mem.sv
module cplx_dual_mem
  import cdm_pkg::*;
#(
  parameter int          HAW       = 32,
  parameter int          WAW       = 12,
  parameter logic [31:0] HOST_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stripe,
  input  logic              a_valid,
  input  logic              a_write,
  input  logic [WAW-1:0]    a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic              a_rvalid,
  output logic [WORD_W-1:0] a_rdata,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [HAW-1:0]    h_addr,
  input  logic [HALF_W-1:0] h_wdata,
  output logic              h_rvalid,
  output logic [HALF_W-1:0] h_rdata
);
  localparam int IAW = WAW - 1;

  logic [WAW-1:0]    hx_addr;
  logic              hx_imag;
  logic [LANES-1:0]  hx_lane;
  logic [WORD_W-1:0] hx_wdata;

  cdm_host_xlate #(.HAW(HAW), .WAW(WAW), .HOST_BASE(HOST_BASE)) u_xlate (
    .haddr(h_addr), .hwdata(h_wdata), .word_addr(hx_addr),
    .imag_sel(hx_imag), .lane_mask(hx_lane), .wide_wdata(hx_wdata)
  );

  // fixed priority: the accelerator always owns the cycle it asks for
  logic              h_go, any_go, sel_wr;
  logic [WAW-1:0]    sel_addr;
  logic [LANES-1:0]  sel_lane;
  logic [WORD_W-1:0] sel_wdata;

  assign h_ready   = !a_valid;
  assign h_go      = h_valid && h_ready;
  assign any_go    = a_valid || h_go;
  assign sel_addr  = a_valid ? a_addr  : hx_addr;
  assign sel_wr    = a_valid ? a_write : h_write;
  assign sel_lane  = a_valid ? '1      : hx_lane;
  assign sel_wdata = a_valid ? a_wdata : hx_wdata;

  logic [IAW-1:0]   bank_idx;
  logic [BANKS-1:0] bank_hit;
  logic             rd_bank;

  cdm_bank_route #(.WAW(WAW)) u_route (
    .stripe(cfg_stripe), .word_addr(sel_addr),
    .idx(bank_idx), .bank_hit(bank_hit), .rd_bank(rd_bank)
  );

  logic [WORD_W-1:0] bank_rd [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    cdm_bank #(.IAW(IAW)) u_bank (
      .clk(clk), .en(any_go && bank_hit[b]), .wr(sel_wr), .lane(sel_lane),
      .idx(bank_idx), .wdata(sel_wdata), .rdata(bank_rd[b])
    );
  end

  logic a_rv_q, h_rv_q, rd_bank_q, imag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rv_q    <= 1'b0;
      h_rv_q    <= 1'b0;
      rd_bank_q <= 1'b0;
      imag_q    <= 1'b0;
    end else begin
      a_rv_q <= a_valid && !a_write;
      h_rv_q <= h_go && !h_write;
      if (any_go && !sel_wr) rd_bank_q <= rd_bank;
      if (h_go && !h_write)  imag_q    <= hx_imag;
    end
  end

  assign a_rvalid = a_rv_q;
  assign h_rvalid = h_rv_q;
  assign a_rdata  = bank_rd[rd_bank_q];
  assign h_rdata  = imag_q ? a_rdata[WORD_W-1:HALF_W] : a_rdata[HALF_W-1:0];
endmodule

// File: rtl/cplx_dual_mem_chk.sv
module cplx_dual_mem_chk #(
  parameter int HAW = 32,
  parameter int WAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_stripe,
  input logic           a_valid,
  input logic           a_write,
  input logic [WAW-1:0] a_addr,
  input logic [63:0]    a_wdata,
  input logic           a_rvalid,
  input logic [63:0]    a_rdata,
  input logic           h_valid,
  input logic           h_ready,
  input logic           h_write,
  input logic [HAW-1:0] h_addr,
  input logic [31:0]    h_wdata,
  input logic           h_rvalid,
  input logic [31:0]    h_rdata
);
  logic           pw_vld, pw_mode, exp_vld;
  logic [WAW-1:0] pw_addr;
  logic [63:0]    pw_data, exp_data;
  logic           unused_in;

  assign unused_in = ^{h_addr, h_wdata, h_rdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_vld  <= 1'b0;
      exp_vld <= 1'b0;
    end else begin
      pw_vld  <= a_valid && a_write;
      pw_addr <= a_addr;
      pw_data <= a_wdata;
      pw_mode <= cfg_stripe;
      exp_vld <= a_valid && !a_write && pw_vld && (a_addr == pw_addr) && (cfg_stripe == pw_mode);
      exp_data <= pw_data;
    end
  end

  // R1
  a_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_write |=> a_rvalid);

  // R1
  a_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vld |-> a_rdata == exp_data);

  // R4
  h_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && h_ready && !h_write |=> h_rvalid);

  // R7
  accel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && h_valid |=> !h_rvalid);

  // R7
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rvalid && h_rvalid));
endmodule

bind cplx_dual_mem cplx_dual_mem_chk #(.HAW(HAW), .WAW(WAW)) u_chk (.*);

// File: tb/test_cplx_dual_mem.sv
`timescale 1ns/1ps
module test_cplx_dual_mem;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [1:0] OP_AW = 2'd0, OP_AR = 2'd1, OP_HW = 2'd2, OP_HR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        mode;
    logic [31:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{OP_AW, 1'b1, 32'd5,           64'h1111_2222_3333_4444, 64'h0},
    '{OP_AR, 1'b1, 32'd5,           64'h0, 64'h1111_2222_3333_4444}, // R1 R5
    '{OP_HR, 1'b1, BASE + 32'd40,   64'h0, 64'h3333_4444},           // R2 R4
    '{OP_HR, 1'b1, BASE + 32'd44,   64'h0, 64'h1111_2222},           // R3
    '{OP_HW, 1'b1, BASE + 32'd44,   64'hDEAD_BEEF, 64'h0},
    '{OP_AR, 1'b1, 32'd5,           64'h0, 64'hDEAD_BEEF_3333_4444}, // R3
    '{OP_AW, 1'b1, 32'd6,           64'hAAAA_0000_0000_0006, 64'h0},
    '{OP_AW, 1'b1, 32'd7,           64'hBBBB_0000_0000_0007, 64'h0},
    '{OP_AR, 1'b1, 32'd6,           64'h0, 64'hAAAA_0000_0000_0006}, // R5
    '{OP_AR, 1'b1, 32'd7,           64'h0, 64'hBBBB_0000_0000_0007}, // R5
    '{OP_AW, 1'b1, 32'd2053,        64'hCCCC_CCCC_0000_0805, 64'h0},
    '{OP_AR, 1'b1, 32'd5,           64'h0, 64'hDEAD_BEEF_3333_4444}, // R5
    '{OP_AR, 1'b1, 32'd2053,        64'h0, 64'hCCCC_CCCC_0000_0805}, // R5
    '{OP_AW, 1'b0, 32'd10,          64'h0D0D_0D0D_1010_1010, 64'h0},
    '{OP_AR, 1'b0, 32'd2058,        64'h0, 64'h0D0D_0D0D_1010_1010}, // R6
    '{OP_AW, 1'b0, 32'd20,          64'h2020_2020_0202_0202, 64'h0},
    '{OP_HW, 1'b0, BASE + 32'd164,  64'hE1E1_E1E1, 64'h0},
    '{OP_HR, 1'b0, BASE + 32'd16548, 64'h0, 64'hE1E1_E1E1},          // R6 R2
    '{OP_AR, 1'b1, 32'd40,          64'h0, 64'hE1E1_E1E1_0202_0202}, // R6
    '{OP_AR, 1'b1, 32'd41,          64'h0, 64'hE1E1_E1E1_0202_0202}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_stripe = 1'b1;
  logic        a_valid = 1'b0, a_write = 1'b0;
  logic [11:0] a_addr = '0;
  logic [63:0] a_wdata = '0;
  logic        a_rvalid;
  logic [63:0] a_rdata;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic        h_ready;
  logic [31:0] h_addr = '0, h_wdata = '0;
  logic        h_rvalid;
  logic [31:0] h_rdata;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  cplx_dual_mem i_cplx_dual_mem (
    .clk(clk), .rst_n(rst_n), .cfg_stripe(cfg_stripe),
    .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic apply(input vec_t v, input int n);
    @(negedge clk);
    cfg_stripe = v.mode;
    if (v.op == OP_AW || v.op == OP_AR) begin
      a_valid = 1'b1; a_write = (v.op == OP_AW);
      a_addr = v.addr[11:0]; a_wdata = v.data;
    end else begin
      h_valid = 1'b1; h_write = (v.op == OP_HW);
      h_addr = v.addr; h_wdata = v.data[31:0];
    end
    @(negedge clk);
    a_valid = 1'b0; h_valid = 1'b0;
    if (v.op == OP_AR) begin
      check($sformatf("vec %0d a_rvalid (R1)", n), 64'(a_rvalid), 64'd1);
      check($sformatf("vec %0d a_rdata", n), a_rdata, v.exp);
    end else if (v.op == OP_HR) begin
      check($sformatf("vec %0d h_rvalid (R4)", n), 64'(h_rvalid), 64'd1);
      check($sformatf("vec %0d h_rdata", n), 64'(h_rdata), v.exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset a_rvalid R8", 64'(a_rvalid), 64'd0);
    check("reset h_rvalid R8", 64'(h_rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("idle a_rvalid R8", 64'(a_rvalid), 64'd0);
    check("idle h_rvalid R8", 64'(h_rvalid), 64'd0);
    check("idle h_ready R8", 64'(h_ready), 64'd1);

    for (int i = 0; i < NV; i++) apply(VT[i], i);

    // R7 contention: accel read against host write to real half of word 5
    @(negedge clk);
    cfg_stripe = 1'b1;
    a_valid = 1'b1; a_write = 1'b0; a_addr = 12'd5;
    h_valid = 1'b1; h_write = 1'b1; h_addr = BASE + 32'd40; h_wdata = 32'h5555_5555;
    #1 check("h_ready low under contention R7", 64'(h_ready), 64'd0);
    @(negedge clk);
    check("accel served first R7", a_rdata, 64'hDEAD_BEEF_3333_4444);
    check("accel rvalid R7", 64'(a_rvalid), 64'd1);
    a_valid = 1'b0;
    #1 check("h_ready back high R8", 64'(h_ready), 64'd1);
    @(negedge clk);
    h_valid = 1'b0;
    apply('{OP_AR, 1'b1, 32'd5, 64'h0, 64'hDEAD_BEEF_5555_5555}, 100); // R7 held host write landed

    // R7 contention: accel write to word 6 against host read of its real half
    @(negedge clk);
    a_valid = 1'b1; a_write = 1'b1; a_addr = 12'd6; a_wdata = 64'h6666_6666_7777_7777;
    h_valid = 1'b1; h_write = 1'b0; h_addr = BASE + 32'd48;
    @(negedge clk);
    a_valid = 1'b0;
    check("no host rvalid after contention R7", 64'(h_rvalid), 64'd0);
    @(negedge clk);
    h_valid = 1'b0;
    check("held host read rvalid R7", 64'(h_rvalid), 64'd1);
    check("held host read sees new data R7", 64'(h_rdata), 64'h7777_7777);

    wrap_up();
  end
endmodule